// File: doc/BRIEF.md
# Serial Audio Port

This block is a stereo serial audio port that runs on the bit clock. It watches the left/right clock, receives one serial data line into 24-bit parallel samples, and sends a pair of 24-bit parallel samples out on one serial data line. An 8-bit format control value selects one of thirteen framings. The framings are left-justified, right-justified or I2S at 16, 18, 20 or 24 bits in a 64-clock frame, plus a 16-bit mode in a 32-clock frame.

Time is counted in slots. A slot is one bit-clock rising edge. Slot 0 of a half-frame is the rising edge at which the sampled left/right clock first differs from its value at the previous edge. Slot s is the s-th edge after that. On receive, the data bit sampled at slot s belongs to slot s. On transmit, the bit for slot s is driven during the cycle that follows the edge of slot s. An external receiver therefore captures the MSB on the rising edge after the left/right clock change. The format is taken from the control input only at slot 0, so one setting applies to a whole half-frame.

Top module: `serial_audio_port`

## Requirements
- R1: With fmt_ctrl bit 6 = 0, a half-frame has 16 slots and carries a 16-bit left-justified word (MSB in slot 0), and the left channel is the half where lrck is high. Bits 5-4 and 1-0 are ignored in this mode.
- R2: With fmt_ctrl bit 6 = 1, a half-frame has 32 slots, and bits 5-4 select the alignment. 00 puts the MSB in slot 0. 01 (right-justified) puts the LSB in slot 31. 10 (I2S) puts the MSB in slot 1. 11 behaves as 00.
- R3: With fmt_ctrl bit 6 = 1, bits 1-0 select the word length: 00 = 16, 01 = 18, 10 = 20, 11 = 24 bits. A received word is left-aligned in rx_data, and the bits below its LSB are 0.
- R4: The half-frame where lrck is high is the left channel in every mode except I2S. In I2S the half where lrck is low is the left channel.
- R5: The word of a half-frame is published at slot 0 of the following half-frame. In the cycle after that edge, rx_valid is 1 for exactly one cycle, and rx_data and rx_is_left hold that word and its channel. Both hold their values until the next publication.
- R6: The transmitted word is sent MSB first, in the same slots a received word of that format would use. It is made of the top word-length bits of the 24-bit input. Every other slot drives sdout = 0.
- R7: At slot 0 the transmitter takes the word from tx_left or tx_right, according to the channel of the new half-frame. Changes to those inputs later in the half-frame do not affect it.
- R8: fmt_ctrl is sampled only at slot 0. A change in the middle of a half-frame has no effect on that half-frame's reception or transmission.
- R9: In reset, sdout, rx_valid and rx_data are 0. The partial half-frame before the first lrck change after reset is discarded and produces no rx_valid.
- R10: Received bits in slots outside the word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all logic uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Left/right clock, sampled on the rising edge |
| sdin | input | 1 | Serial receive data |
| fmt_ctrl | input | 8 | Format control: bit 6 frame length, bits 5-4 alignment, bits 1-0 word length |
| tx_left | input | 24 | Left sample to transmit, MSB-aligned |
| tx_right | input | 24 | Right sample to transmit, MSB-aligned |
| sdout | output | 1 | Serial transmit data |
| rx_data | output | 24 | Received sample, MSB-aligned, zero-filled below the LSB |
| rx_is_left | output | 1 | Channel of rx_data: 1 = left |
| rx_valid | output | 1 | One-cycle pulse when a received sample is published |

## Verification
At slot 0 of each half-frame, the block does two things on the same edge. It closes and publishes the previous received word, and it launches the first transmit slot of the new word. At that same edge it also takes in a possibly new format. The bench provokes this at every half-frame boundary. It also changes format between consecutive frames, where the published word must still be decoded with the old format while the transmitted word already uses the new one. Both are judged at the ports: a scoreboard matches each rx_valid pulse against the queued expected word and channel, and the transmitted bits of each half-frame are rebuilt and compared against the parallel input. Some half-frames also change fmt_ctrl and the transmit inputs partway through, to show that only slot 0 sampling counts.

// File: rtl/sap_pkg.sv
package sap_pkg;

  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned SLOT_W   = 6;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned IDX_W    = $clog2(SAMPLE_W);

  typedef logic [SLOT_W-1:0] slot_t;
  localparam slot_t SLOT_MAX = '1;

  typedef enum logic [1:0] {
    ALN_LEFT  = 2'd0,
    ALN_RIGHT = 2'd1,
    ALN_I2S   = 2'd2
  } align_e;

  typedef struct packed {
    logic       long_frame;
    align_e     align;
    logic [1:0] wsel;
  } fmt_t;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } slot_hit_t;

  function automatic fmt_t decode_fmt(input logic [CTRL_W-1:0] c);
    fmt_t f;
    f.long_frame = c[6];
    if (!c[6]) begin
      f.align = ALN_LEFT;
      f.wsel  = 2'd0;
    end else begin
      unique case (c[5:4])
        2'b01:   f.align = ALN_RIGHT;
        2'b10:   f.align = ALN_I2S;
        default: f.align = ALN_LEFT;
      endcase
      f.wsel = c[1:0];
    end
    return f;
  endfunction

  function automatic slot_t word_bits(input fmt_t f);
    slot_t w;
    unique case (f.wsel)
      2'd0:    w = slot_t'(16);
      2'd1:    w = slot_t'(18);
      2'd2:    w = slot_t'(20);
      default: w = slot_t'(24);
    endcase
    return w;
  endfunction

  function automatic slot_t half_slots(input fmt_t f);
    return f.long_frame ? slot_t'(32) : slot_t'(16);
  endfunction

  function automatic slot_t first_slot(input fmt_t f);
    slot_t s;
    unique case (f.align)
      ALN_RIGHT: s = half_slots(f) - word_bits(f);
      ALN_I2S:   s = slot_t'(1);
      default:   s = '0;
    endcase
    return s;
  endfunction

  // Map a slot number to a bit of the MSB-aligned sample word.
  function automatic slot_hit_t slot_pos(input fmt_t f, input slot_t s);
    slot_hit_t r;
    slot_t     first;
    slot_t     rel;
    first = first_slot(f);
    rel   = s - first;
    r.hit = (s >= first) && (rel < word_bits(f));
    r.idx = IDX_W'(SAMPLE_W - 1) - rel[IDX_W-1:0];
    return r;
  endfunction

  function automatic logic [SAMPLE_W-1:0] word_mask(input fmt_t f);
    logic [SAMPLE_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(SAMPLE_W); i++) begin
      if (i >= int'(SAMPLE_W) - int'(word_bits(f))) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/sap_rst_sync.sv
module sap_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/sap_framer.sv
module sap_framer
  import sap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lrck_i,
  input  logic [CTRL_W-1:0] fmt_ctrl_i,
  output logic              edge_o,
  output slot_t             slot_o,
  output fmt_t              fmt_o,
  output logic              left_o,
  output fmt_t              fmt_q_o,
  output slot_t             slot_q_o,
  output logic              prev_left_o,
  output logic              synced_o
);

  logic  started_q, started_d;
  logic  lr_q, lr_d;
  logic  synced_q, synced_d;
  slot_t cnt_q, cnt_d;
  fmt_t  fmt_q, fmt_d;

  logic  boundary;
  slot_t cur_slot;
  fmt_t  fmt_eff;

  always_comb begin
    boundary = started_q & (lrck_i ^ lr_q);
    fmt_eff  = boundary ? decode_fmt(fmt_ctrl_i) : fmt_q;
    if (boundary) begin
      cur_slot = '0;
    end else if (cnt_q == SLOT_MAX) begin
      cur_slot = SLOT_MAX;
    end else begin
      cur_slot = cnt_q + slot_t'(1);
    end
    started_d = 1'b1;
    lr_d      = lrck_i;
    synced_d  = synced_q | boundary;
    cnt_d     = cur_slot;
    fmt_d     = fmt_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      lr_q      <= 1'b0;
      synced_q  <= 1'b0;
      cnt_q     <= SLOT_MAX;
      fmt_q     <= '0;
    end else begin
      started_q <= started_d;
      lr_q      <= lr_d;
      synced_q  <= synced_d;
      cnt_q     <= cnt_d;
      fmt_q     <= fmt_d;
    end
  end

  assign edge_o      = boundary;
  assign slot_o      = cur_slot;
  assign fmt_o       = fmt_eff;
  assign left_o      = (fmt_eff.align == ALN_I2S) ? ~lrck_i : lrck_i;
  assign fmt_q_o     = fmt_q;
  assign slot_q_o    = cnt_q;
  assign prev_left_o = (fmt_q.align == ALN_I2S) ? ~lr_q : lr_q;
  assign synced_o    = synced_q;

  AST_FMT_HELD_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && (lrck_i == lr_q)) |=> $stable(fmt_q)); // R8

endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sdin_i,
  input  logic                edge_i,
  input  slot_t               slot_i,
  input  fmt_t                fmt_i,
  input  fmt_t                fmt_q_i,
  input  logic                prev_left_i,
  input  logic                synced_i,
  output logic [SAMPLE_W-1:0] rx_data_o,
  output logic                rx_left_o,
  output logic                rx_valid_o
);

  logic [SAMPLE_W-1:0] acc_q, acc_d;
  logic [SAMPLE_W-1:0] data_q, data_d;
  logic                left_q, left_d;
  logic                valid_q, valid_d;
  logic [SAMPLE_W-1:0] contrib;
  slot_hit_t           pos;
  logic                publish;

  always_comb begin
    pos     = slot_pos(fmt_i, slot_i);
    contrib = '0;
    if (pos.hit) contrib[pos.idx] = sdin_i;
    acc_d   = edge_i ? contrib : (acc_q | contrib);
    publish = edge_i & synced_i;
    data_d  = publish ? acc_q : data_q;
    left_d  = publish ? prev_left_i : left_q;
    valid_d = publish;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      data_q  <= '0;
      left_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      data_q  <= data_d;
      left_q  <= left_d;
      valid_q <= valid_d;
    end
  end

  assign rx_data_o  = data_q;
  assign rx_left_o  = left_q;
  assign rx_valid_o = valid_q;

  AST_RX_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> ((data_q & ~word_mask($past(fmt_q_i))) == '0)); // R3

  AST_RX_NO_VALID_UNSYNCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> synced_i); // R9

endmodule

// File: rtl/sap_tx.sv
module sap_tx
  import sap_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                edge_i,
  input  slot_t               slot_i,
  input  fmt_t                fmt_i,
  input  logic                left_i,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  input  slot_t               slot_q_i,
  input  fmt_t                fmt_q_i,
  output logic                sdout_o
);

  logic [SAMPLE_W-1:0] word_q, word_d;
  logic                sdout_q, sdout_d;
  slot_hit_t           pos;

  always_comb begin
    if (edge_i) begin
      word_d = left_i ? tx_left_i : tx_right_i;
    end else begin
      word_d = word_q;
    end
    pos     = slot_pos(fmt_i, slot_i);
    sdout_d = pos.hit ? word_d[pos.idx] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      sdout_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      sdout_q <= sdout_d;
    end
  end

  assign sdout_o = sdout_q;

  AST_TX_QUIET_PAST_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q_i >= half_slots(fmt_q_i)) |-> !sdout_q); // R6

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lrck,
  input  logic                sdin,
  input  logic [CTRL_W-1:0]   fmt_ctrl,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                sdout,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_is_left,
  output logic                rx_valid
);

  logic  rst_sn;
  logic  edge_w;
  slot_t slot_w;
  fmt_t  fmt_w;
  logic  left_w;
  fmt_t  fmt_q_w;
  slot_t slot_q_w;
  logic  prev_left_w;
  logic  synced_w;

  sap_rst_sync u_rst_sync (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sn)
  );

  sap_framer u_framer (
    .clk_i       (clk),
    .rst_ni      (rst_sn),
    .lrck_i      (lrck),
    .fmt_ctrl_i  (fmt_ctrl),
    .edge_o      (edge_w),
    .slot_o      (slot_w),
    .fmt_o       (fmt_w),
    .left_o      (left_w),
    .fmt_q_o     (fmt_q_w),
    .slot_q_o    (slot_q_w),
    .prev_left_o (prev_left_w),
    .synced_o    (synced_w)
  );

  sap_rx u_rx (
    .clk_i       (clk),
    .rst_ni      (rst_sn),
    .sdin_i      (sdin),
    .edge_i      (edge_w),
    .slot_i      (slot_w),
    .fmt_i       (fmt_w),
    .fmt_q_i     (fmt_q_w),
    .prev_left_i (prev_left_w),
    .synced_i    (synced_w),
    .rx_data_o   (rx_data),
    .rx_left_o   (rx_is_left),
    .rx_valid_o  (rx_valid)
  );

  sap_tx u_tx (
    .clk_i      (clk),
    .rst_ni     (rst_sn),
    .edge_i     (edge_w),
    .slot_i     (slot_w),
    .fmt_i      (fmt_w),
    .left_i     (left_w),
    .tx_left_i  (tx_left),
    .tx_right_i (tx_right),
    .slot_q_i   (slot_q_w),
    .fmt_q_i    (fmt_q_w),
    .sdout_o    (sdout)
  );

  AST_VALID_ON_LRCK_CHANGE: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_valid |-> ($past(lrck) != $past(lrck, 2))); // R5

endmodule

// File: tb/serial_audio_port_bench.sv
module serial_audio_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        lrck;
  logic        sdin;
  logic [7:0]  fmt_ctrl;
  logic [23:0] tx_left;
  logic [23:0] tx_right;
  logic        sdout;
  logic [23:0] rx_data;
  logic        rx_is_left;
  logic        rx_valid;

  int n_vec;
  int n_bad;
  logic [31:0] seed;

  logic [24:0] exp_q[$];
  string       tag_q[$];

  serial_audio_port u_serial_audio_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .lrck       (lrck),
    .sdin       (sdin),
    .fmt_ctrl   (fmt_ctrl),
    .tx_left    (tx_left),
    .tx_right   (tx_right),
    .sdout      (sdout),
    .rx_data    (rx_data),
    .rx_is_left (rx_is_left),
    .rx_valid   (rx_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
    n_vec++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  // Independent model of the format control (from the requirements)
  function automatic int m_w(input logic [7:0] m);
    if (!m[6]) return 16;
    case (m[1:0])
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int m_h(input logic [7:0] m);
    return m[6] ? 32 : 16;
  endfunction

  function automatic int m_al(input logic [7:0] m); // 0 LJ, 1 RJ, 2 I2S
    if (!m[6]) return 0;
    if (m[5:4] == 2'b01) return 1;
    if (m[5:4] == 2'b10) return 2;
    return 0;
  endfunction

  function automatic int m_off(input logic [7:0] m);
    if (m_al(m) == 1) return m_h(m) - m_w(m);
    if (m_al(m) == 2) return 1;
    return 0;
  endfunction

  function automatic logic [23:0] m_mask(input int w);
    return 24'hFFFFFF << (24 - w);
  endfunction

  function automatic logic [23:0] rnd24();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[31:8];
  endfunction

  // One half-frame: drive lrck/sdin per slot, collect sdout, queue rx expectation
  task automatic send_half(input logic [7:0] m, input logic lv, input logic [23:0] w,
                           input logic [23:0] tl, input logic [23:0] tr,
                           input bit push, input bit txchk, input bit glitch,
                           input string req);
    int h, wd, off;
    logic is_left, fill;
    logic [63:0] txb;
    logic [23:0] got, expw;
    logic stray;
    h = m_h(m); wd = m_w(m); off = m_off(m);
    is_left = (m_al(m) == 2) ? ~lv : lv;
    fill = w[0]; // unused slots carry junk (R10)
    txb = '0;
    for (int s = 0; s < h; s++) begin
      if (s == 0) begin
        fmt_ctrl = m; tx_left = tl; tx_right = tr;
      end
      if (glitch && s == h/2) begin
        fmt_ctrl = m ^ 8'h73; tx_left = ~tl; tx_right = ~tr;
      end
      if (glitch && s == h-1) fmt_ctrl = m;
      lrck = lv;
      sdin = (s >= off && s - off < wd) ? w[23 - (s - off)] : fill;
      @(negedge clk);
      txb[s] = sdout;
    end
    if (txchk) begin
      got = '0; stray = 1'b0;
      for (int s = 0; s < h; s++) begin
        if (s >= off && s - off < wd) got[23 - (s - off)] = txb[s];
        else if (txb[s]) stray = 1'b1;
      end
      expw = (is_left ? tl : tr) & m_mask(wd);
      chk(glitch ? "R7 tx word held" : "R6 tx word", {8'h0, got}, {8'h0, expw});
      chk("R6 unused tx slots zero", {31'h0, stray}, 32'h0);
    end
    if (push) begin
      exp_q.push_back({is_left, w & m_mask(wd)});
      tag_q.push_back(req);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R5/R9: unexpected rx_valid, got %h expected none", {rx_is_left, rx_data});
      end else begin
        logic [24:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " rx word"}, {7'h0, rx_is_left, rx_data}, {7'h0, e});
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  logic [7:0] modes [16];
  string      tags  [16];

  initial begin
    logic last_lv;
    logic [7:0] m;
    n_vec = 0; n_bad = 0; seed = 32'h1234_5678;
    rst_n = 1'b0; lrck = 1'b0; sdin = 1'b1; fmt_ctrl = 8'h00;
    tx_left = 24'hA5A5A5; tx_right = 24'h5A5A5A;
    modes = '{8'h00, 8'h33, 8'h40, 8'h50, 8'h60, 8'h41, 8'h51, 8'h61,
              8'h42, 8'h52, 8'h62, 8'h43, 8'h53, 8'h63, 8'h70, 8'h00};
    tags  = '{"R1", "R1", "R2", "R2", "R4", "R3", "R8", "R3",
              "R3", "R10", "R8", "R3", "R2", "R4", "R2", "R5"};

    repeat (3) @(negedge clk);
    chk("R9 reset sdout", {31'h0, sdout}, 32'h0);
    chk("R9 reset rx_valid", {31'h0, rx_valid}, 32'h0);
    chk("R9 reset rx_data", {8'h0, rx_data}, 32'h0);
    rst_n = 1'b1;

    // Lead-in with lrck steady: discarded, no publication
    send_half(8'h00, 1'b0, 24'hFFFFFF, 24'h0, 24'h0, 1'b0, 1'b0, 1'b0, "R9");
    chk("R9 no valid before sync", {31'h0, rx_valid}, 32'h0);
    chk("R9 sdout quiet before sync", {31'h0, sdout}, 32'h0);
    last_lv = 1'b0;

    for (int i = 0; i < 16; i++) begin
      logic fl;
      bit g;
      m  = modes[i];
      fl = (m_al(m) == 2) ? 1'b0 : 1'b1;
      g  = (tags[i] == "R8");
      if (last_lv == fl)
        send_half(m, ~fl, rnd24(), rnd24(), rnd24(), 1'b1, 1'b1, 1'b0, "R4 pad");
      begin
        logic [23:0] tl, tr;
        tl = rnd24(); tr = rnd24();
        send_half(m, fl,  rnd24(), tl, tr, 1'b1, 1'b1, g, tags[i]);
        send_half(m, ~fl, rnd24(), tl, tr, 1'b1, 1'b1, g, tags[i]);
      end
      last_lv = ~fl;
    end

    // Trailing half publishes the last word
    send_half(8'h00, ~last_lv, 24'h0, 24'h0, 24'h0, 1'b0, 1'b1, 1'b0, "R5");
    repeat (2) @(negedge clk);
    chk("R5 all words published", exp_q.size(), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule